// File: doc/BRIEF.md
# Indexed Host Port with Display-RAM Access

This block is the host-facing register port of a graphics display controller. A host drives chip select, register select, write and read strobes and an 8-bit data bus. All of them are sampled on one system clock. With register select low, a write loads a register number into an index register. With register select high, the access goes to the data register named by that number. The number stays in place, so the same data register can be accessed any number of times in a row.

The data registers are a control register, a column (X) address, a row (Y) address and a memory port into an internal byte-wide display RAM. Reads through the memory port are pipelined by one access: each read returns the byte captured by the previous read, then captures the byte at the current address. After every memory access one coordinate steps on its own. Y steps when the direction bit is clear and X steps when it is set. X wraps at a limit chosen by a width bit. Rows past the populated range take part in stepping but never reach the RAM.

Top module: `hostport_top`

## Requirements
- R1: After reset, `dout` is 0x00, the read buffer is 0x00, X and Y are 0 and both control bits are 0. The first memory read after reset therefore returns 0x00.
- R2: A write with `rs`=0 stores `din[3:0]` as the register number. Accesses with `rs`=1 go to that register until the number is written again.
- R3: Register 1 (control: bit 0 = step direction, bit 1 = width select), register 2 (X) and register 3 (Y) are write-only and read as 0x00. A read with `rs`=0 returns 0x00. Numbers 0 and 5 to 15 read as 0x00 and ignore writes. Reads of any register other than 4 leave the read buffer untouched.
- R4: A read of register 4 drives `dout` with the byte held in the read buffer, then loads the buffer with the byte at (X, Y). `dout` changes only on a read access.
- R5: With the direction bit at 0, every access to register 4 increments Y and leaves X unchanged.
- R6: With the direction bit at 1, every access to register 4 increments X and leaves Y unchanged. X returns to 0 after 0x27 when the width bit is 0, and after 0x35 when the width bit is 1.
- R7: Y is 7 bits wide and steps from 0x7F to 0x00.
- R8: Only Y from 0x00 to 0x4F (and X up to 0x35) addresses real memory. A write outside that range changes no byte, and a read outside it loads 0x00 into the read buffer.
- R9: Writing X or Y does not change the read buffer.
- R10: An access happens once, on the first clock at which `cs_n` is low and its strobe is low after having been high. Holding a strobe low does not repeat the access. Strobes with `cs_n` high are ignored.
- R11: X takes `din[5:0]` and Y takes `din[6:0]`. The remaining data bits are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | Register select: 0 = index register, 1 = data register |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| din | input | 8 | Write data from the host |
| dout | output | 8 | Read data to the host, held until the next read |

## Verification
The assertions assume that the host never drives both strobes low in the same cycle, and that each strobe returns high for at least one clock between accesses. The bench builds every transfer from tasks that lower a single strobe for one clock and raise it again on the next falling edge. The one deliberate exception is a read strobe held low for several clocks, which still holds only the read strobe low. Stepping checks assume that no register write falls in the same cycle as a memory access, and the single-strobe discipline guarantees this.

// File: rtl/hostport_pkg.sv
package hostport_pkg;
  localparam int IDX_W = 4;

  typedef logic [IDX_W-1:0] reg_id_t;

  localparam reg_id_t REG_CTRL = 4'd1;
  localparam reg_id_t REG_XADR = 4'd2;
  localparam reg_id_t REG_YADR = 4'd3;
  localparam reg_id_t REG_MEM  = 4'd4;

  localparam int CTRL_DIR_BIT  = 0;
  localparam int CTRL_WIDE_BIT = 1;

  typedef struct packed {
    logic wide;
    logic dir;
  } ctrl_t;
endpackage

// File: rtl/hp_edge.sv
module hp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic strobe_n,
  output logic go
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = strobe_n;
    go     = ~sel_n & ~strobe_n & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/hp_regs.sv
module hp_regs
  import hostport_pkg::*;
#(
  parameter int DW       = 8,
  parameter int XW       = 6,
  parameter int YW       = 7,
  parameter int X_NARROW = 39,
  parameter int X_WIDE   = 53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_go,
  input  logic          mem_go,
  input  logic          rs,
  input  logic [DW-1:0] din,
  output reg_id_t       idx,
  output ctrl_t         ctrl,
  output logic [XW-1:0] xadr,
  output logic [YW-1:0] yadr
);
  localparam logic [XW-1:0] LIM_N = XW'(X_NARROW);
  localparam logic [XW-1:0] LIM_W = XW'(X_WIDE);

  reg_id_t       idx_d;
  ctrl_t         ctrl_d;
  logic [XW-1:0] x_d;
  logic [YW-1:0] y_d;
  logic [XW-1:0] x_lim;
  logic          data_wr;

  always_comb begin
    data_wr = wr_go & rs;
    x_lim   = ctrl.wide ? LIM_W : LIM_N;
    idx_d   = idx;
    ctrl_d  = ctrl;
    x_d     = xadr;
    y_d     = yadr;
    if (wr_go && !rs) idx_d = din[IDX_W-1:0];
    if (data_wr && idx == REG_CTRL) begin
      ctrl_d.dir  = din[CTRL_DIR_BIT];
      ctrl_d.wide = din[CTRL_WIDE_BIT];
    end
    if (data_wr && idx == REG_XADR) x_d = din[XW-1:0];
    if (data_wr && idx == REG_YADR) y_d = din[YW-1:0];
    if (mem_go) begin
      if (ctrl.dir) begin
        if (xadr >= x_lim) x_d = '0;
        else               x_d = xadr + 1'b1;
      end else begin
        y_d = yadr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx  <= '0;
      ctrl <= '0;
      xadr <= '0;
      yadr <= '0;
    end else begin
      idx  <= idx_d;
      ctrl <= ctrl_d;
      xadr <= x_d;
      yadr <= y_d;
    end
  end
endmodule

// File: rtl/hp_dram.sv
module hp_dram #(
  parameter int DW    = 8,
  parameter int DEPTH = 4320,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          valid,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rbuf
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rbuf_d;

  always_comb begin
    rbuf_d = rbuf;
    if (rd_en) rbuf_d = valid ? mem[addr] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en && valid) mem[addr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbuf <= '0;
    else        rbuf <= rbuf_d;
  end
endmodule

// File: rtl/hostport_top.sv
module hostport_top
  import hostport_pkg::*;
#(
  parameter int DW       = 8,
  parameter int XW       = 6,
  parameter int YW       = 7,
  parameter int X_COLS   = 54,
  parameter int Y_ROWS   = 80,
  parameter int X_NARROW = 39,
  parameter int X_WIDE   = 53
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rs,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  localparam int DEPTH = X_COLS * Y_ROWS;
  localparam int AW    = $clog2(DEPTH);
  localparam int NSTB  = 2;

  logic [1:0]      rst_sync;
  logic            rst_i;
  logic [NSTB-1:0] strb_n;
  logic [NSTB-1:0] go;
  logic            wr_go;
  logic            rd_go;
  logic            mem_go;
  logic            mem_rd;
  logic            mem_wr;
  reg_id_t         idx;
  ctrl_t           ctrl;
  logic [XW-1:0]   xadr;
  logic [YW-1:0]   yadr;
  logic            loc_ok;
  logic [AW-1:0]   lin;
  logic [DW-1:0]   rbuf;
  logic [DW-1:0]   dout_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  assign strb_n = {rd_n, wr_n};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    hp_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_i),
      .sel_n    (cs_n),
      .strobe_n (strb_n[g]),
      .go       (go[g])
    );
  end

  always_comb begin
    wr_go  = go[0];
    rd_go  = go[1] & ~go[0];
    mem_wr = wr_go & rs & (idx == REG_MEM);
    mem_rd = rd_go & rs & (idx == REG_MEM);
    mem_go = mem_wr | mem_rd;
    loc_ok = (yadr < YW'(Y_ROWS)) && (xadr < XW'(X_COLS));
    lin    = AW'(yadr) * AW'(X_COLS) + AW'(xadr);
  end

  hp_regs #(
    .DW(DW), .XW(XW), .YW(YW), .X_NARROW(X_NARROW), .X_WIDE(X_WIDE)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_i),
    .wr_go  (wr_go),
    .mem_go (mem_go),
    .rs     (rs),
    .din    (din),
    .idx    (idx),
    .ctrl   (ctrl),
    .xadr   (xadr),
    .yadr   (yadr)
  );

  hp_dram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_dram (
    .clk   (clk),
    .rst_n (rst_i),
    .wr_en (mem_wr),
    .rd_en (mem_rd),
    .valid (loc_ok),
    .addr  (lin),
    .wdata (din),
    .rbuf  (rbuf)
  );

  always_comb begin
    dout_d = dout;
    if (rd_go) dout_d = mem_rd ? rbuf : '0;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) dout <= '0;
    else        dout <= dout_d;
  end
endmodule

// File: rtl/hostport_chk.sv
module hostport_chk #(
  parameter int DW       = 8,
  parameter int XW       = 6,
  parameter int YW       = 7,
  parameter int X_NARROW = 39,
  parameter int X_WIDE   = 53
) (
  input logic          clk,
  input logic          rst_i,
  input logic          cs_n,
  input logic          rd_go,
  input logic          mem_go,
  input logic          mem_rd,
  input logic          loc_ok,
  input logic [1:0]    ctrl,
  input logic [XW-1:0] xadr,
  input logic [YW-1:0] yadr,
  input logic [DW-1:0] rbuf,
  input logic [DW-1:0] dout
);
  logic [XW-1:0] lim;
  assign lim = ctrl[1] ? XW'(X_WIDE) : XW'(X_NARROW);

  AST_RD_PIPE: assert property (@(posedge clk) disable iff (!rst_i)
    mem_rd |=> dout == $past(rbuf)); // R4
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_go |=> $stable(dout)); // R4
  AST_OTHER_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_i)
    (rd_go && !mem_rd) |=> dout == '0); // R3
  AST_Y_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_go && !ctrl[0]) |=> (yadr == YW'($past(yadr) + 1'b1)) && $stable(xadr)); // R5
  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_go && ctrl[0] && xadr < lim) |=> (xadr == XW'($past(xadr) + 1'b1)) && $stable(yadr)); // R6
  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_go && ctrl[0] && xadr >= lim) |=> xadr == '0); // R6
  AST_BAD_RD: assert property (@(posedge clk) disable iff (!rst_i)
    (mem_rd && !loc_ok) |=> rbuf == '0); // R8
  AST_IDLE: assert property (@(posedge clk) disable iff (!rst_i)
    cs_n |=> $stable(xadr) && $stable(yadr) && $stable(rbuf)); // R10
endmodule

bind hostport_top hostport_chk #(
  .DW(DW), .XW(XW), .YW(YW), .X_NARROW(X_NARROW), .X_WIDE(X_WIDE)
) u_chk (
  .clk    (clk),
  .rst_i  (rst_i),
  .cs_n   (cs_n),
  .rd_go  (rd_go),
  .mem_go (mem_go),
  .mem_rd (mem_rd),
  .loc_ok (loc_ok),
  .ctrl   ({ctrl.wide, ctrl.dir}),
  .xadr   (xadr),
  .yadr   (yadr),
  .rbuf   (rbuf),
  .dout   (dout)
);

// File: tb/hostport_top_test.sv
module hostport_top_test;
  localparam int TCLK = 10;
  localparam int NX = 54;
  localparam int NY = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic rs = 1'b0;
  logic wr_n = 1'b1;
  logic rd_n = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  hostport_top uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs),
    .wr_n(wr_n), .rd_n(rd_n), .din(din), .dout(dout)
  );

  always #(TCLK/2) clk = ~clk;

  function automatic logic [7:0] pat(int x, int y);
    return 8'((x * 13 + y * 7 + 1) ^ (y << 2));
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic r, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; rs = r; din = d; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
  endtask

  task automatic rd(input logic r, output logic [7:0] q);
    @(negedge clk); cs_n = 1'b0; rs = r; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1; cs_n = 1'b1; q = dout;
  endtask

  task automatic set_reg(input logic [7:0] n, input logic [7:0] d);
    wr(1'b0, n); wr(1'b1, d);
  endtask

  task automatic set_xy(input int x, input int y);
    set_reg(8'd2, 8'(x)); set_reg(8'd3, 8'(y)); wr(1'b0, 8'd4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 dout after reset", dout, 8'h00);
    wr(1'b0, 8'd4);
    rd(1'b1, q);
    chk("R1 first read returns reset buffer", q, 8'h00);

    // Fill: direction 1, width 1; rows written left to right
    set_reg(8'd1, 8'h03);
    for (int y = 0; y < NY; y++) begin
      set_xy(0, y);
      for (int x = 0; x < NX; x++) wr(1'b1, pat(x, y));
    end

    // Read back column by column with direction 0 (R2 index held, R4, R5)
    set_reg(8'd1, 8'h00);
    for (int x = 0; x < NX; x++) begin
      set_xy(x, 0);
      rd(1'b1, q);
      for (int y = 1; y <= NY; y++) begin
        rd(1'b1, q);
        chk("R2/R4/R5/R6 sweep readback", q, pat(x, y - 1));
      end
    end

    // R9: address writes keep the buffer
    set_xy(3, 10);
    rd(1'b1, q);
    rd(1'b1, q);
    chk("R4 pipelined read", q, pat(3, 10));
    set_xy(5, 20);
    rd(1'b1, q);
    chk("R9 buffer kept over X/Y write", q, pat(3, 11));

    // R8: invalid rows
    set_xy(2, 8'h50);
    wr(1'b1, 8'hAA);
    set_xy(2, 8'h4F);
    rd(1'b1, q);
    rd(1'b1, q);
    chk("R8 last valid row", q, pat(2, 8'h4F));
    rd(1'b1, q);
    chk("R8 invalid row reads zero", q, 8'h00);

    // R7: Y wrap
    set_xy(1, 8'h7F);
    wr(1'b1, 8'h5A);
    wr(1'b1, 8'hC3);
    set_xy(1, 0);
    rd(1'b1, q);
    rd(1'b1, q);
    chk("R7 Y wraps 7F to 00", q, 8'hC3);

    // R6: X wrap, narrow and wide
    set_reg(8'd1, 8'h01);
    set_xy(8'h27, 6);
    wr(1'b1, 8'h11);
    wr(1'b1, 8'h22);
    set_reg(8'd1, 8'h03);
    set_xy(8'h35, 7);
    wr(1'b1, 8'h33);
    wr(1'b1, 8'h44);
    set_reg(8'd1, 8'h00);
    set_xy(0, 6);
    rd(1'b1, q); rd(1'b1, q);
    chk("R6 narrow wrap lands on X=0", q, 8'h22);
    rd(1'b1, q);
    chk("R6 wide wrap lands on X=0", q, 8'h44);
    set_xy(8'h27, 6);
    rd(1'b1, q); rd(1'b1, q);
    chk("R6 narrow limit byte", q, 8'h11);
    set_xy(8'h35, 7);
    rd(1'b1, q); rd(1'b1, q);
    chk("R6 wide limit byte", q, 8'h33);
    set_xy(8'h28, 6);
    rd(1'b1, q); rd(1'b1, q);
    chk("R6 narrow wrap skipped 28", q, pat(8'h28, 6));

    // R3: write-only and unimplemented registers
    set_xy(4, 9);
    rd(1'b1, q);
    wr(1'b0, 8'd2); rd(1'b1, q);
    chk("R3 X register reads zero", q, 8'h00);
    wr(1'b0, 8'd1); rd(1'b1, q);
    chk("R3 control register reads zero", q, 8'h00);
    wr(1'b0, 8'd7); rd(1'b1, q);
    chk("R3 unimplemented reads zero", q, 8'h00);
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'd0); wr(1'b1, 8'hFF);
    rd(1'b0, q);
    chk("R3 index read zero", q, 8'h00);
    wr(1'b0, 8'd4);
    rd(1'b1, q);
    chk("R3 buffer and state untouched", q, pat(4, 9));
    rd(1'b1, q);
    chk("R3 stepping unchanged by ignored writes", q, pat(4, 10));

    // R11: unused data bits
    set_reg(8'd2, 8'hC5);
    set_reg(8'd3, 8'h8A);
    wr(1'b0, 8'd4);
    rd(1'b1, q); rd(1'b1, q);
    chk("R11 upper data bits dropped", q, pat(5, 10));

    // R10: deselected strobes and held strobes
    @(negedge clk); cs_n = 1'b1; rs = 1'b1; rd_n = 1'b0;
    @(negedge clk); rd_n = 1'b1;
    chk("R10 read with cs high ignored", dout, pat(5, 10));
    @(negedge clk); din = 8'hEE; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); cs_n = 1'b0; rs = 1'b1; rd_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_n = 1'b1; cs_n = 1'b1;
    chk("R10 held strobe single access", dout, pat(5, 11));
    rd(1'b1, q);
    chk("R10 no extra step from held strobe", q, pat(5, 12));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule